// File: doc/BRIEF.md
# Priority Packet Receive Buffer with Hardware Remote-Read Service

This block is the receive side of a processing element on a packet network. Each packet is two words: an address word and a data word. Ordinary packets go into one of two priority queues. These are thread invocations, remote writes and remote reads that software is to serve. The thread dispatcher draws from the queues one packet per request. The high-priority queue is always served first, and each queue hands out packets in the order they arrived. Packets keep flowing in while the dispatcher is idle or busy, as long as the target queue has room.

System remote-read requests never reach the dispatcher. The block reads local memory through a one-cycle synchronous read port. It then emits a two-word reply, addressed to the continuation carried in the request's data word, with the fetched value as its data word. Only one such read is in flight at a time. While the reply output is stalled, further system reads are refused. Ordinary traffic keeps moving during that time.

Top module: `pktrx_front`

## Requirements
- R1: After reset, `disp_valid`, `rep_valid` and `mem_rd_en` are low and `in_ready` is high for any packet.
- R2: Within one priority level, packets leave at the dispatch output in arrival order, address and data words unchanged. A packet stays at the head until `disp_pop` is high while `disp_valid` is high.
- R3: Address bit W-3 selects the level (1 = high). Whenever the high queue holds a packet, the dispatch output shows a high packet, ahead of any low one.
- R4: Address bits [W-1:W-2] give the packet kind: 00 thread invocation, 01 user remote read, 10 remote write, 11 system remote read. Kinds 00, 01 and 10 are queued and never start a memory read.
- R5: Each level holds DEPTH (8) packets. When a level is full, `in_ready` is low for packets bound to it. Packets for the other level are still accepted.
- R6: A system remote read is accepted only when `in_ready` is high. In its accept cycle, `mem_rd_en` is high and `mem_rd_addr` equals `in_addr[MEM_AW-1:0]`. Two clocks later `rep_valid` is high, with `rep_addr` equal to the request's `in_data` and `rep_data` equal to the memory word. The request never appears at the dispatch output.
- R7: System reads are served one at a time. From acceptance until its reply is taken, `in_ready` is low for further system reads. While `rep_ready` is low, the reply stays valid and its words stay unchanged.
- R8: While a system read is outstanding or its reply is stalled, queued packets are still accepted and dispatched. This includes cycles in which the reply handshake, a push and a pop all happen together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming packet present |
| in_ready | output | 1 | Incoming packet can be taken this cycle |
| in_addr | input | W | Packet address word (kind, level, local address) |
| in_data | input | W | Packet data word (continuation for system reads) |
| disp_pop | input | 1 | Dispatcher takes the head packet |
| disp_valid | output | 1 | A queued packet is at the dispatch output |
| disp_addr | output | W | Head packet address word |
| disp_data | output | W | Head packet data word |
| mem_rd_en | output | 1 | Local memory read strobe |
| mem_rd_addr | output | MEM_AW | Local memory read address |
| mem_rd_data | input | W | Memory word, valid one cycle after the strobe |
| rep_valid | output | 1 | Reply packet present |
| rep_ready | input | 1 | Reply packet taken this cycle |
| rep_addr | output | W | Reply address word (continuation) |
| rep_data | output | W | Reply data word (fetched value) |

## Verification
The reply handshake of the hardware read path and the queue traffic can fall in the same clock. In that cycle, a new ordinary packet is pushed while the dispatcher pops the head of the other level. The bench stalls a reply, parks an ordinary packet, and then in one cycle raises `rep_ready`, `disp_pop` and a new high-priority packet together. It judges the outcome at the ports. The reply must drop, the popped packet must be gone, the new packet must be at the dispatch head, and a second system read refused earlier must now be accepted and answered correctly.

// File: rtl/pktrx_pkg.sv
package pktrx_pkg;

  // packet kind carried in the two top bits of the address word
  typedef enum logic [1:0] {
    PK_INVOKE = 2'b00,
    PK_UREAD  = 2'b01,
    PK_WRITE  = 2'b10,
    PK_SREAD  = 2'b11
  } pkt_kind_e;

  // hardware read service sequencer
  typedef enum logic [1:0] {
    SR_IDLE  = 2'b00,
    SR_FETCH = 2'b01,
    SR_SEND  = 2'b10
  } sread_state_e;

  localparam int NUM_LEVELS = 2;
  localparam int LVL_LO     = 0;
  localparam int LVL_HI     = 1;

endpackage

// File: rtl/pktrx_classify.sv
module pktrx_classify
  import pktrx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] addr,
  output pkt_kind_e    kind,
  output logic         is_sys,
  output logic         is_hi
);

  function automatic pkt_kind_e kind_of(input logic [W-1:0] a);
    return pkt_kind_e'(a[W-1 -: 2]);
  endfunction

  function automatic logic level_of(input logic [W-1:0] a);
    return a[W-3];
  endfunction

  always_comb begin
    kind   = kind_of(addr);
    is_sys = (kind == PK_SREAD);
    is_hi  = level_of(addr);
  end

endmodule

// File: rtl/pktrx_fifo.sv
module pktrx_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           push_word,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wr_ptr;
  logic [PW-1:0]    rd_ptr;
  logic [CW-1:0]    cnt_q;
  logic             do_push;
  logic             do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign head    = store[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/pktrx_pick.sv
module pktrx_pick #(
  parameter int W = 32
) (
  input  logic         hi_empty,
  input  logic         lo_empty,
  input  logic [2*W-1:0] hi_head,
  input  logic [2*W-1:0] lo_head,
  input  logic         disp_pop,
  output logic         disp_valid,
  output logic [W-1:0] disp_addr,
  output logic [W-1:0] disp_data,
  output logic         pop_hi,
  output logic         pop_lo
);

  logic use_hi;

  always_comb begin
    use_hi     = !hi_empty;
    disp_valid = !hi_empty || !lo_empty;
    {disp_addr, disp_data} = use_hi ? hi_head : lo_head;
    pop_hi     = disp_pop && use_hi;
    pop_lo     = disp_pop && !use_hi && !lo_empty;
  end

endmodule

// File: rtl/pktrx_sread.sv
module pktrx_sread
  import pktrx_pkg::*;
#(
  parameter int W      = 32,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      req_addr,
  input  logic [W-1:0]      req_cont,
  output logic              idle,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [W-1:0]      mem_rd_data,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [W-1:0]      rep_addr,
  output logic [W-1:0]      rep_data
);

  sread_state_e state_q;
  logic [W-1:0] cont_q;
  logic [W-1:0] value_q;

  function automatic logic [MEM_AW-1:0] local_of(input logic [W-1:0] a);
    return a[MEM_AW-1:0];
  endfunction

  assign idle        = (state_q == SR_IDLE);
  assign mem_rd_en   = start && idle;
  assign mem_rd_addr = local_of(req_addr);
  assign rep_valid   = (state_q == SR_SEND);
  assign rep_addr    = cont_q;
  assign rep_data    = value_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SR_IDLE;
      cont_q  <= '0;
      value_q <= '0;
    end else begin
      case (state_q)
        SR_IDLE: if (mem_rd_en) begin
          cont_q  <= req_cont;
          state_q <= SR_FETCH;
        end
        SR_FETCH: begin
          value_q <= mem_rd_data;
          state_q <= SR_SEND;
        end
        SR_SEND: if (rep_ready) state_q <= SR_IDLE;
        default: state_q <= SR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pktrx_front.sv
module pktrx_front
  import pktrx_pkg::*;
#(
  parameter int W      = 32,
  parameter int DEPTH  = 8,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_addr,
  input  logic [W-1:0]      in_data,
  input  logic              disp_pop,
  output logic              disp_valid,
  output logic [W-1:0]      disp_addr,
  output logic [W-1:0]      disp_data,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [W-1:0]      mem_rd_data,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [W-1:0]      rep_addr,
  output logic [W-1:0]      rep_data
);

  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = 2 * W;

  pkt_kind_e         in_kind;
  logic              in_is_sys;
  logic              in_is_hi;
  logic              sr_idle;
  logic              tgt_full;
  logic              accept;
  logic              sr_start;
  logic [NUM_LEVELS-1:0] lvl_push;
  logic [NUM_LEVELS-1:0] lvl_pop;
  logic [NUM_LEVELS-1:0] lvl_empty;
  logic [NUM_LEVELS-1:0] lvl_full;
  logic [PW-1:0]     lvl_head  [NUM_LEVELS];
  logic [CW-1:0]     lvl_count [NUM_LEVELS];
  logic [CW-1:0]     hi_count;
  logic [CW-1:0]     lo_count;

  pktrx_classify #(.W(W)) u_cls (
    .addr   (in_addr),
    .kind   (in_kind),
    .is_sys (in_is_sys),
    .is_hi  (in_is_hi)
  );

  assign tgt_full = in_is_hi ? lvl_full[LVL_HI] : lvl_full[LVL_LO];
  assign in_ready = in_is_sys ? sr_idle : !tgt_full;
  assign accept   = in_valid && in_ready;
  assign sr_start = accept && in_is_sys;

  assign lvl_push[LVL_HI] = accept && !in_is_sys && in_is_hi;
  assign lvl_push[LVL_LO] = accept && !in_is_sys && !in_is_hi;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    pktrx_fifo #(.WIDTH(PW), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (lvl_push[l]),
      .push_word ({in_addr, in_data}),
      .pop       (lvl_pop[l]),
      .head      (lvl_head[l]),
      .empty     (lvl_empty[l]),
      .full      (lvl_full[l]),
      .count     (lvl_count[l])
    );
  end

  assign hi_count = lvl_count[LVL_HI];
  assign lo_count = lvl_count[LVL_LO];

  pktrx_pick #(.W(W)) u_pick (
    .hi_empty   (lvl_empty[LVL_HI]),
    .lo_empty   (lvl_empty[LVL_LO]),
    .hi_head    (lvl_head[LVL_HI]),
    .lo_head    (lvl_head[LVL_LO]),
    .disp_pop   (disp_pop),
    .disp_valid (disp_valid),
    .disp_addr  (disp_addr),
    .disp_data  (disp_data),
    .pop_hi     (lvl_pop[LVL_HI]),
    .pop_lo     (lvl_pop[LVL_LO])
  );

  pktrx_sread #(.W(W), .MEM_AW(MEM_AW)) u_sr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (sr_start),
    .req_addr    (in_addr),
    .req_cont    (in_data),
    .idle        (sr_idle),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .rep_valid   (rep_valid),
    .rep_ready   (rep_ready),
    .rep_addr    (rep_addr),
    .rep_data    (rep_data)
  );

endmodule

// File: rtl/pktrx_front_chk.sv
module pktrx_front_chk #(
  parameter int W      = 32,
  parameter int DEPTH  = 8,
  parameter int MEM_AW = 10,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [W-1:0]      in_addr,
  input logic [W-1:0]      in_data,
  input logic              disp_valid,
  input logic [W-1:0]      disp_addr,
  input logic              mem_rd_en,
  input logic              rep_valid,
  input logic              rep_ready,
  input logic [W-1:0]      rep_addr,
  input logic [W-1:0]      rep_data,
  input logic [CW-1:0]     hi_count
);

  // R4
  queued_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[W-1 -: 2] != 2'b11) |-> !mem_rd_en);

  // R6
  reply_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> ##1 (rep_valid && rep_addr == $past(in_data, 2)));

  // R7
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> !mem_rd_en);

  // R7
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R7
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_addr) && $stable(rep_data)));

  // R3
  hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_count != '0) |-> (disp_valid && disp_addr[W-3]));

  // R5
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_count == CW'(DEPTH) && in_valid && in_addr[W-1 -: 2] != 2'b11 && in_addr[W-3])
      |-> !in_ready);

endmodule

bind pktrx_front pktrx_front_chk #(
  .W(W), .DEPTH(DEPTH), .MEM_AW(MEM_AW), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_addr    (in_addr),
  .in_data    (in_data),
  .disp_valid (disp_valid),
  .disp_addr  (disp_addr),
  .mem_rd_en  (mem_rd_en),
  .rep_valid  (rep_valid),
  .rep_ready  (rep_ready),
  .rep_addr   (rep_addr),
  .rep_data   (rep_data),
  .hi_count   (hi_count)
);

// File: tb/pktrx_front_bench.sv
`timescale 1ns/1ps
module pktrx_front_bench;

  localparam int W      = 32;
  localparam int DEPTH  = 8;
  localparam int MEM_AW = 10;
  localparam int NV     = 6;

  // stimulus table: {address word, data word}; kind in [31:30], level in [29]
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0011, 32'hD000_0000},
    {32'h2000_0012, 32'hD000_0001},
    {32'h4000_0013, 32'hD000_0002},
    {32'hA000_0014, 32'hD000_0003},
    {32'h8000_0015, 32'hD000_0004},
    {32'h6000_0016, 32'hD000_0005}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [W-1:0]      in_addr = '0;
  logic [W-1:0]      in_data = '0;
  logic              disp_pop = 1'b0;
  logic              disp_valid;
  logic [W-1:0]      disp_addr;
  logic [W-1:0]      disp_data;
  logic              mem_rd_en;
  logic [MEM_AW-1:0] mem_rd_addr;
  logic [W-1:0]      mem_rd_data = '0;
  logic              rep_valid;
  logic              rep_ready = 1'b1;
  logic [W-1:0]      rep_addr;
  logic [W-1:0]      rep_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pktrx_front #(.W(W), .DEPTH(DEPTH), .MEM_AW(MEM_AW)) u_pktrx_front (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .disp_pop(disp_pop), .disp_valid(disp_valid), .disp_addr(disp_addr), .disp_data(disp_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_addr(rep_addr), .rep_data(rep_data)
  );

  function automatic logic [W-1:0] mem_word(input logic [MEM_AW-1:0] a);
    logic [W-1:0] x;
    x = W'(a);
    return (x << 16) ^ (x * 32'd37) ^ 32'h5A00_00C3;
  endfunction

  // memory model, one-cycle read latency
  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [W-1:0] ea, input logic [W-1:0] ed);
    @(negedge clk);
    #1;
    chk(req, W'(disp_valid), 1);
    chk(req, disp_addr, ea);
    chk(req, disp_data, ed);
    disp_pop = 1'b1;
    @(posedge clk);
    #1;
    disp_pop = 1'b0;
  endtask

  // system read with ready reply: strobe, then reply two clocks after accept
  task automatic sread(input string req, input logic [MEM_AW-1:0] la, input logic [W-1:0] cont);
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'hC000_0000 | W'(la); in_data = cont;
    #1;
    chk(req, W'(in_ready), 1);
    chk(req, W'(mem_rd_en), 1);
    chk(req, W'(mem_rd_addr), W'(la));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    @(negedge clk);
    #1;
    chk(req, W'(rep_valid), 0);
    @(negedge clk);
    #1;
    chk(req, W'(rep_valid), 1);
    chk(req, rep_addr, cont);
    chk(req, rep_data, mem_word(la));
    chk(req, W'(disp_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    in_addr = 32'h0000_0001;
    #1;
    chk("R1 disp_valid", W'(disp_valid), 0);
    chk("R1 rep_valid", W'(rep_valid), 0);
    chk("R1 mem_rd_en", W'(mem_rd_en), 0);
    chk("R1 in_ready", W'(in_ready), 1);

    // table walk: R2, R3, R4
    for (int i = 0; i < NV; i++) begin
      push(VEC[i][63:32], VEC[i][31:0]);
    end
    for (int pass = 1; pass >= 0; pass--) begin
      for (int i = 0; i < NV; i++) begin
        if (VEC[i][32+29] == pass[0])
          pop_check(pass ? "R3 R4 hi order" : "R2 R4 lo order", VEC[i][63:32], VEC[i][31:0]);
      end
    end
    @(negedge clk); #1;
    chk("R2 drained", W'(disp_valid), 0);

    // R5 full low level, high still accepted
    for (int i = 0; i < DEPTH; i++) push(32'h0000_0100 + W'(i), 32'hE000_0000 + W'(i));
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h0000_01FF; in_data = 32'h1;
    #1;
    chk("R5 lo full", W'(in_ready), 0);
    in_addr = 32'h2000_02AA; in_data = 32'hBEEF_0001;
    #1;
    chk("R5 hi open", W'(in_ready), 1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    pop_check("R3 hi over full lo", 32'h2000_02AA, 32'hBEEF_0001);
    for (int i = 0; i < DEPTH; i++)
      pop_check("R5 R2 lo drain", 32'h0000_0100 + W'(i), 32'hE000_0000 + W'(i));

    // R6 system read with ready reply
    rep_ready = 1'b1;
    sread("R6 sread", 10'h02A, 32'hC0DE_0001);
    @(negedge clk); #1;
    chk("R6 reply taken", W'(rep_valid), 0);

    // R7 / R8 stalled reply
    @(negedge clk);
    rep_ready = 1'b0;
    sread("R6 stalled sread", 10'h155, 32'hC0DE_0002);
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'hC000_0077; in_data = 32'hC0DE_0003;
    #1;
    chk("R7 second sread refused", W'(in_ready), 0);
    chk("R7 no strobe", W'(mem_rd_en), 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    push(32'h0000_0333, 32'hAAAA_0001);
    repeat (2) @(negedge clk);
    #1;
    chk("R7 hold valid", W'(rep_valid), 1);
    chk("R7 hold addr", rep_addr, 32'hC0DE_0002);
    chk("R7 hold data", rep_data, mem_word(10'h155));
    chk("R8 queued while busy", W'(disp_valid), 1);

    // R8 reply handshake, pop and push in one cycle
    @(negedge clk);
    rep_ready = 1'b1; disp_pop = 1'b1;
    in_valid = 1'b1; in_addr = 32'h2000_0444; in_data = 32'hAAAA_0002;
    #1;
    chk("R8 push open", W'(in_ready), 1);
    chk("R8 pop head", disp_addr, 32'h0000_0333);
    @(posedge clk); #1;
    in_valid = 1'b0; disp_pop = 1'b0;
    @(negedge clk); #1;
    chk("R8 reply gone", W'(rep_valid), 0);
    pop_check("R8 new head", 32'h2000_0444, 32'hAAAA_0002);
    @(negedge clk); #1;
    chk("R8 empty", W'(disp_valid), 0);
    sread("R7 later sread", 10'h077, 32'hC0DE_0003);

    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule